// File: doc/BRIEF.md
# DRAM Strobe and Enable Generator

This block sits between the bus of a 16-bit embedded processor and a bank of asynchronous DRAM. It watches the DRAM chip select, the address strobe and a clock-phase qualifier. When all three are active in the same clock cycle it starts a row-strobe pulse of fixed length. While the pulse is low, the block steers the two byte-lane column strobes, the DRAM output enable and the DRAM write enable. It uses the byte enables, the read/write indication and a refresh flag for this. All of these were captured on the cycle that started the pulse.

A refresh is RAS-only. The row strobe fires as it does for any access, and every other strobe stays high. No data flows through the block, so it has no valid/ready handshake. Every pin is a plain control level. Its only form of back-pressure is this: a start request made while a pulse is running is dropped, and the bus master must leave the strobe to time out.

The default is `RAS_CYCLES` = 8, which gives 80 ns at a 100 MHz clock and meets the roughly 75 ns row-strobe time. The default `CAS_DELAY` is 1 cycle of row-to-column spacing.

Top module: `dram_strobe_gen`

## Requirements
- R1: In a cycle where `cs_n`=0, `ads_n`=0, `phase`=1 and no pulse is running, `ras_n` goes low after the next rising clock edge.
- R2: Once started, `ras_n` stays low for exactly `RAS_CYCLES` clock cycles and then returns high.
- R3: If `cs_n`=1, `ads_n`=1 or `phase`=0, no pulse starts, and all five outputs stay high.
- R4: When `rfsh`=1 at the start, `ras_n` pulses normally while `ucas_n`, `lcas_n`, `oe_n` and `we_n` all stay high for the whole pulse.
- R5: Outside refresh, `lcas_n` goes low during the column window only if `ble_n` was 0 at the start. `ucas_n` does the same only if `bhe_n` was 0. This holds on both reads and writes.
- R6: On a read (`wr_n`=1) that is not a refresh, `oe_n` is low during the column window if at least one byte enable was 0, and `we_n` stays high. With both byte enables at 1, `oe_n` stays high.
- R7: On a write (`wr_n`=0) that is not a refresh, `we_n` is low during the column window and `oe_n` stays high.
- R8: The column window opens `CAS_DELAY` cycles after `ras_n` falls and lasts until `ras_n` rises. No column strobe is ever low while `ras_n` is high.
- R9: During reset and after every pulse ends, all five outputs are high.
- R10: A start request made while a pulse is running is ignored. The pulse length and the captured attributes do not change. A request still held when the pulse ends starts a new pulse after exactly one high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | DRAM chip select, active low |
| ads_n | input | 1 | Bus-cycle address strobe, active low |
| phase | input | 1 | Clock-phase qualifier, active high |
| wr_n | input | 1 | 0 = write, 1 = read |
| ble_n | input | 1 | Low byte enable, active low |
| bhe_n | input | 1 | High byte enable, active low |
| rfsh | input | 1 | Marks the cycle as a RAS-only refresh |
| ras_n | output | 1 | Row strobe |
| ucas_n | output | 1 | Upper byte-lane column strobe |
| lcas_n | output | 1 | Lower byte-lane column strobe |
| oe_n | output | 1 | DRAM output enable |
| we_n | output | 1 | DRAM write enable |

## Verification
The embedded assertions check on every cycle the rules that hold in all cases:
- The pulse ends only after its full count.
- A running pulse cannot be cut short or restarted.
- The captured attributes stay frozen during a pulse.
- No column strobe appears outside the row strobe or in its first cycle.
- Output and write enables are never low together.
- A refresh leaves every strobe but the row strobe high.

Only the directed scenarios can show that each byte-enable and read/write combination produces the right set of strobes, cycle by cycle. They also show that a missing qualifier starts nothing, that a request during a pulse leaves the pulse unchanged, and that a held request re-arms after one high cycle.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

  // Attributes of a bus cycle, captured when the row strobe starts.
  typedef struct packed {
    logic       write;  // 1 = write cycle
    logic       rfsh;   // 1 = RAS-only refresh
    logic [1:0] lane;   // [1] high byte, [0] low byte, 1 = enabled
  } dsg_cycle_t;

endpackage

// File: rtl/dsg_row_timer.sv
module dsg_row_timer #(
  parameter int RAS_CYCLES = 8,
  parameter int CAS_DELAY  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic accept_o,
  output logic active_o,
  output logic col_win_o
);

  localparam int CNT_W = (RAS_CYCLES > 2) ? $clog2(RAS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(RAS_CYCLES - 1);
  localparam logic [CNT_W-1:0] COL_BEG = CNT_W'(CAS_DELAY);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = req_i && !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (req_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end else if (cnt_q == LAST) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o  = active_q;
  assign col_win_o = active_q && (cnt_q >= COL_BEG);

  // R2
  ras_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(cnt_q) == LAST);

  // R10
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != LAST) |=> active_q);

endmodule

// File: rtl/dsg_cycle_capture.sv
module dsg_cycle_capture
  import dsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       active_i,
  input  logic       wr_n_i,
  input  logic       ble_n_i,
  input  logic       bhe_n_i,
  input  logic       rfsh_i,
  output dsg_cycle_t cyc_o
);

  dsg_cycle_t cyc_d, cyc_q;

  always_comb begin
    cyc_d.write = !wr_n_i;
    cyc_d.rfsh  = rfsh_i;
    cyc_d.lane  = {!bhe_n_i, !ble_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (load_i) cyc_q <= cyc_d;
  end

  assign cyc_o = cyc_q;

  // R10
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !load_i) |=> $stable(cyc_q));

endmodule

// File: rtl/dsg_strobe_steer.sv
module dsg_strobe_steer
  import dsg_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             col_win_i,
  input  dsg_cycle_t       cyc_i,
  output logic [LANES-1:0] cas_n_o,
  output logic             oe_n_o,
  output logic             we_n_o
);

  logic access_win;
  logic any_lane;

  assign access_win = col_win_i && !cyc_i.rfsh;
  assign any_lane   = |cyc_i.lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n_o[g] = !(access_win && cyc_i.lane[g]);
  end

  assign oe_n_o = !(access_win && !cyc_i.write && any_lane);
  assign we_n_o = !(access_win && cyc_i.write);

  // R8
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cas_n_o)) |-> active_i);

  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_o && !we_n_o));

  // R4
  rfsh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && cyc_i.rfsh) |-> ((&cas_n_o) && oe_n_o && we_n_o));

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
  import dsg_pkg::*;
#(
  parameter int RAS_CYCLES = 8,
  parameter int CAS_DELAY  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ads_n,
  input  logic phase,
  input  logic wr_n,
  input  logic ble_n,
  input  logic bhe_n,
  input  logic rfsh,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n,
  output logic oe_n,
  output logic we_n
);

  localparam int LANES = 2;

  logic             req, accept, active, col_win;
  dsg_cycle_t       cyc;
  logic [LANES-1:0] cas_n;

  assign req = !cs_n && !ads_n && phase;

  dsg_row_timer #(
    .RAS_CYCLES (RAS_CYCLES),
    .CAS_DELAY  (CAS_DELAY)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .accept_o  (accept),
    .active_o  (active),
    .col_win_o (col_win)
  );

  dsg_cycle_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .active_i (active),
    .wr_n_i   (wr_n),
    .ble_n_i  (ble_n),
    .bhe_n_i  (bhe_n),
    .rfsh_i   (rfsh),
    .cyc_o    (cyc)
  );

  dsg_strobe_steer #(
    .LANES (LANES)
  ) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (active),
    .col_win_i (col_win),
    .cyc_i     (cyc),
    .cas_n_o   (cas_n),
    .oe_n_o    (oe_n),
    .we_n_o    (we_n)
  );

  assign ras_n  = !active;
  assign ucas_n = cas_n[1];
  assign lcas_n = cas_n[0];

  // R8
  cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ucas_n && lcas_n));

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |-> (ucas_n && lcas_n && oe_n && we_n));

  initial begin
    assert (RAS_CYCLES >= 2) else $error("RAS_CYCLES must be at least 2");
    assert (CAS_DELAY >= 1 && CAS_DELAY < RAS_CYCLES)
      else $error("CAS_DELAY must lie in 1..RAS_CYCLES-1");
  end

endmodule

// File: tb/sim_dram_strobe_gen.sv
module sim_dram_strobe_gen;

  localparam int RC = 8;
  localparam int CD = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ads_n = 1'b1, phase = 1'b0;
  logic wr_n = 1'b1, ble_n = 1'b1, bhe_n = 1'b1, rfsh = 1'b0;
  logic ras_n, ucas_n, lcas_n, oe_n, we_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dram_strobe_gen #(.RAS_CYCLES(RC), .CAS_DELAY(CD)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ads_n(ads_n), .phase(phase),
    .wr_n(wr_n), .ble_n(ble_n), .bhe_n(bhe_n), .rfsh(rfsh),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .oe_n(oe_n), .we_n(we_n)
  );

  // vector order: {ras_n, ucas_n, lcas_n, oe_n, we_n}
  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {ras_n, ucas_n, lcas_n, oe_n, we_n};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: {ras,ucas,lcas,oe,we} actual=%b expected=%b",
               req, $time, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_at(int i, logic w_n, logic bl_n,
                                           logic bh_n, logic rf);
    logic cw, lo, hi;
    cw = (i >= CD) && !rf;
    lo = !bl_n;
    hi = !bh_n;
    return {1'b0, !(cw && hi), !(cw && lo),
            !(cw && w_n && (lo || hi)), !(cw && !w_n)};
  endfunction

  task automatic drive_start(input logic w_n, input logic bl_n,
                             input logic bh_n, input logic rf);
    cs_n = 1'b0; ads_n = 1'b0; phase = 1'b1;
    wr_n = w_n; ble_n = bl_n; bhe_n = bh_n; rfsh = rf;
  endtask

  task automatic release_bus();
    cs_n = 1'b1; ads_n = 1'b1; phase = 1'b0;
    wr_n = 1'b1; ble_n = 1'b1; bhe_n = 1'b1; rfsh = 1'b0;
  endtask

  // One full access; checks every cycle of the pulse and the idle after it.
  task automatic run_access(input string req, input logic w_n, input logic bl_n,
                            input logic bh_n, input logic rf);
    @(negedge clk); drive_start(w_n, bl_n, bh_n, rf);
    @(negedge clk); release_bus();
    for (int i = 0; i < RC; i++) begin
      check(req, expect_at(i, w_n, bl_n, bh_n, rf));
      @(negedge clk);
    end
    check("R2", 5'b11111);
  endtask

  task automatic t_reset();
    #1 check("R9", 5'b11111);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // R3: each missing qualifier must leave the outputs idle.
  task automatic t_missing(input logic c, input logic a, input logic p);
    @(negedge clk);
    cs_n = c; ads_n = a; phase = p; wr_n = 1'b1; ble_n = 1'b0; bhe_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3", 5'b11111);
    end
    release_bus();
  endtask

  // R10: a request in mid-pulse changes neither the length nor the strobes.
  task automatic t_busy();
    @(negedge clk); drive_start(1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk); release_bus();
    for (int i = 0; i < RC; i++) begin
      check("R10", expect_at(i, 1'b1, 1'b0, 1'b1, 1'b0));
      if (i == 3) drive_start(1'b0, 1'b1, 1'b0, 1'b0);
      if (i == 4) release_bus();
      @(negedge clk);
    end
    check("R10", 5'b11111);
    @(negedge clk);
    check("R10", 5'b11111);
  endtask

  // R10: a held request re-arms after exactly one high cycle.
  task automatic t_rearm();
    @(negedge clk); drive_start(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 2 * RC + 1; i++) begin
      if (i == RC) check("R10", 5'b11111);
      else         check("R10", expect_at(i % (RC + 1), 1'b0, 1'b0, 1'b0, 1'b0));
      if (i == RC + 1) release_bus();
      @(negedge clk);
    end
    check("R10", 5'b11111);
  endtask

  initial begin
    t_reset();
    run_access("R1", 1'b1, 1'b0, 1'b1, 1'b0);  // read, low lane  (R5 R6 R8)
    run_access("R5", 1'b1, 1'b1, 1'b0, 1'b0);  // read, high lane
    run_access("R6", 1'b1, 1'b0, 1'b0, 1'b0);  // read, both lanes
    run_access("R6", 1'b1, 1'b1, 1'b1, 1'b0);  // read, no lanes: oe stays high
    run_access("R7", 1'b0, 1'b0, 1'b0, 1'b0);  // write, both lanes
    run_access("R7", 1'b0, 1'b1, 1'b0, 1'b0);  // write, high lane
    run_access("R4", 1'b1, 1'b0, 1'b0, 1'b1);  // refresh: row strobe only
    run_access("R4", 1'b0, 1'b0, 1'b0, 1'b1);
    t_missing(1'b1, 1'b0, 1'b1);
    t_missing(1'b0, 1'b1, 1'b1);
    t_missing(1'b0, 1'b0, 1'b0);
    t_busy();
    t_rearm();
    run_access("R8", 1'b0, 1'b0, 1'b1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule